// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Transmit-End Flag

This block sends bytes to a smart card over a single half-duplex line. A byte is placed in a holding register, either by a processor write or by a DMA-style write made in answer to the transmit-data-empty request. While transmission is enabled and the holding register is full, the byte moves into the character register and goes out as a start bit, eight data bits (least significant first) and a parity bit. Each bit lasts one elementary time unit (etu), the time of one bit on the line. After the parity bit the line is released, so the card can pull it low to report a bad character. The block samples the line 10.5 etu after the start edge. A low level there sets a sticky error flag, and the same byte is sent again.

Three status flags are kept: holding-register empty, error seen, and transmit end. Transmit end rises 2.5 etu after the parity bit in normal mode, or 1.0 etu after it in early-completion mode. It rises only when no further byte is waiting and no error is flagged. The etu length is a fixed number of input clocks, scaled by a power-of-two prescaler.

Top module: `sc_tx_top`

## Requirements
- R1: After reset the transmit-end flag is 1, the empty flag is 1, the error flag is 0, line_oe is 0 and line_o is 1.
- R2: A character has ten bits: a start bit of 0, the data bits least significant first, then a parity bit. The parity bit makes the count of ones in data plus parity even when par_odd=0, and odd when par_odd=1. Each bit lasts (ETU_CLKS/2 << psel)*2 clocks.
- R3: line_oe is 1 only during the ten character bits, and line_o is 1 whenever line_oe is 0.
- R4: When idle, with tx_en=1 and the empty flag at 0, the held byte moves into the character register on the next edge. The empty flag becomes 1 on the same edge and the start bit is driven from that edge on. txe_req equals tx_en AND the empty flag.
- R5: In normal mode (early_end=0), the transmit-end flag rises 25 half-etu after the start bit begins (2.5 etu after the parity bit), provided the empty flag is 1 and the error flag is 0.
- R6: In early-completion mode (early_end=1), the transmit-end flag rises 22 half-etu after the start bit begins (1.0 etu after the parity bit), under the same conditions as R5.
- R7: The line is sampled 21 half-etu after the start bit begins. A low level sets the error flag and keeps the transmit-end flag at 0. The same byte is then sent again, with its start bit at the time the transmit-end flag would otherwise have risen.
- R8: st_wr with st_wdata[0]=0 clears the empty flag and the transmit-end flag, but only if a st_rd has seen the empty flag at 1 since the flag last became 1. Otherwise the write has no effect.
- R9: dma_wr writes the holding register and clears the empty flag and the transmit-end flag on the next edge.
- R10: While tx_en=0 and the error flag is 0, the transmit-end flag is forced to 1. Dropping tx_en during a character stops it and releases the line on the next edge.
- R11: The error flag stays set until a st_wr with st_wdata[1]=0. A st_wr with st_wdata[1]=1 leaves it set. The transmit-end flag never rises while the error flag is 1.
- R12: If a new byte is waiting when a character finishes, the next start bit follows immediately and the transmit-end flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| early_end | input | 1 | 1 selects early-completion end timing |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| psel | input | PSEL_W | etu prescaler, etu = ETU_CLKS << psel clocks |
| cpu_wr | input | 1 | Processor write strobe for the holding register |
| cpu_data | input | 8 | Processor write data |
| dma_wr | input | 1 | DMA-style write strobe for the holding register |
| dma_data | input | 8 | DMA-style write data |
| st_rd | input | 1 | Status read strobe |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 2 | Status write data: bit 0 empty, bit 1 error; 0 clears |
| line_i | input | 1 | Level sensed on the card line |
| line_o | output | 1 | Level driven on the card line |
| line_oe | output | 1 | Line drive enable |
| txe_req | output | 1 | Transmit-data-empty request |
| flag_empty | output | 1 | Holding register empty |
| flag_err | output | 1 | Error signal seen |
| flag_tend | output | 1 | Transmit end |

## Verification
The assertions check the following on every cycle:
- the line idles high whenever it is released;
- the transmit-end flag stays low while a character is on the line;
- the flag is forced high while transmission is disabled;
- a DMA write clears the flag;
- the flag never rises while the error flag is set;
- the error flag stays sticky.

Only the bench scenarios can show the rest: the bit order and parity of each character, the etu length under both prescaler settings, the exact 22 and 25 half-etu end points, the retransmission of the same byte after a card error, the read-before-clear rule, and back-to-back characters.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HC_W   = 5;

  // half-etu positions counted from the start edge
  localparam logic [HC_W-1:0] HC_CHAR_DONE  = 5'd20;
  localparam logic [HC_W-1:0] HC_SAMPLE     = 5'd20;
  localparam logic [HC_W-1:0] HC_LAST_NORM  = 5'd24;
  localparam logic [HC_W-1:0] HC_LAST_EARLY = 5'd21;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_BUSY = 1'b1
  } tx_state_e;

  function automatic logic char_parity(input logic [BYTE_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
  parameter int unsigned ETU_CLKS = 372,
  parameter int unsigned PSEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [PSEL_W-1:0] psel,
  output logic              half_tick
);

  localparam int unsigned HALF_BASE = ETU_CLKS / 2;
  localparam int unsigned MAX_HALF  = HALF_BASE << ((1 << PSEL_W) - 1);
  localparam int unsigned CW        = $clog2(MAX_HALF + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;
  logic          cnt_en;

  always_comb begin
    limit     = CW'(HALF_BASE) << psel;
    half_tick = run && (cnt_q == limit - CW'(1));
    cnt_en    = run || restart;
    cnt_d     = (restart || half_tick) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sc_tx_framer.sv
module sc_tx_framer
  import sc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              early_end,
  input  logic              par_odd,
  input  logic              pending,
  input  logic [BYTE_W-1:0] hold_data,
  input  logic              half_tick,
  input  logic              line_i,
  output logic              run,
  output logic              restart,
  output logic              line_o,
  output logic              line_oe,
  output logic              load_evt,
  output logic              err_evt,
  output logic              done_evt
);

  tx_state_e         st_q, st_d;
  logic [HC_W-1:0]   hc_q, hc_d, hc_last;
  logic [BYTE_W-1:0] chr_q;
  logic              hit_q, hit_d;
  logic              busy, frame_end, resend;
  logic [3:0]        bit_idx;
  logic              bit_val;

  always_comb begin
    busy      = (st_q == TX_BUSY);
    hc_last   = early_end ? HC_LAST_EARLY : HC_LAST_NORM;
    frame_end = busy && half_tick && (hc_q == hc_last);
    err_evt   = busy && tx_en && half_tick && (hc_q == HC_SAMPLE) && !line_i;
    done_evt  = frame_end && tx_en && !hit_q;
    resend    = frame_end && tx_en && hit_q;
    load_evt  = tx_en && pending && ((st_q == TX_IDLE) || done_evt);
    restart   = load_evt || resend;
    run       = busy;

    st_d  = st_q;
    hc_d  = hc_q;
    hit_d = hit_q;
    if (!tx_en) begin
      st_d  = TX_IDLE;
      hc_d  = '0;
      hit_d = 1'b0;
    end else if (restart) begin
      st_d  = TX_BUSY;
      hc_d  = '0;
      hit_d = 1'b0;
    end else if (frame_end) begin
      st_d = TX_IDLE;
    end else if (busy && half_tick) begin
      hc_d = hc_q + HC_W'(1);
      if (err_evt) hit_d = 1'b1;
    end

    bit_idx = hc_q[4:1];
    if (bit_idx == 4'd0)      bit_val = 1'b0;
    else if (bit_idx == 4'd9) bit_val = char_parity(chr_q, par_odd);
    else                      bit_val = chr_q[3'(bit_idx - 4'd1)];
    line_oe = busy && (hc_q < HC_CHAR_DONE);
    line_o  = line_oe ? bit_val : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      hc_q  <= '0;
      hit_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      hc_q  <= hc_d;
      hit_q <= hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chr_q <= '0;
    else if (load_evt) chr_q <= hold_data;
  end

endmodule

// File: rtl/sc_tx_status.sv
module sc_tx_status
  import sc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              cpu_wr,
  input  logic [BYTE_W-1:0] cpu_data,
  input  logic              dma_wr,
  input  logic [BYTE_W-1:0] dma_data,
  input  logic              st_rd,
  input  logic              st_wr,
  input  logic [1:0]        st_wdata,
  input  logic              load_evt,
  input  logic              err_evt,
  input  logic              done_evt,
  output logic [BYTE_W-1:0] hold_data,
  output logic              empty,
  output logic              err,
  output logic              tend
);

  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              hold_en;
  logic              empty_q, empty_d, armed_q, armed_d;
  logic              err_q, err_d, tend_q, tend_d;
  logic              clr_empty;

  always_comb begin
    hold_en   = cpu_wr || dma_wr;
    hold_d    = dma_wr ? dma_data : cpu_data;
    clr_empty = st_wr && !st_wdata[0] && armed_q && empty_q;

    if (dma_wr)         empty_d = 1'b0;
    else if (load_evt)  empty_d = 1'b1;
    else if (clr_empty) empty_d = 1'b0;
    else                empty_d = empty_q;

    armed_d = empty_d && (armed_q || (st_rd && empty_q)) && !load_evt;

    if (err_evt)                      err_d = 1'b1;
    else if (st_wr && !st_wdata[1])   err_d = 1'b0;
    else                              err_d = err_q;

    if (!tx_en && !err_q)                    tend_d = 1'b1;
    else if (dma_wr || clr_empty)            tend_d = 1'b0;
    else if (done_evt && empty_q && !err_q)  tend_d = 1'b1;
    else                                     tend_d = tend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
      tend_q  <= 1'b1;
    end else begin
      empty_q <= empty_d;
      armed_q <= armed_d;
      err_q   <= err_d;
      tend_q  <= tend_d;
    end
  end

  assign hold_data = hold_q;
  assign empty     = empty_q;
  assign err       = err_q;
  assign tend      = tend_q;

endmodule

// File: rtl/sc_tx_top.sv
module sc_tx_top
  import sc_tx_pkg::*;
#(
  parameter int unsigned ETU_CLKS = 372,
  parameter int unsigned PSEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              early_end,
  input  logic              par_odd,
  input  logic [PSEL_W-1:0] psel,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_data,
  input  logic              dma_wr,
  input  logic [7:0]        dma_data,
  input  logic              st_rd,
  input  logic              st_wr,
  input  logic [1:0]        st_wdata,
  input  logic              line_i,
  output logic              line_o,
  output logic              line_oe,
  output logic              txe_req,
  output logic              flag_empty,
  output logic              flag_err,
  output logic              flag_tend
);

  logic              run, restart, half_tick;
  logic              load_evt, err_evt, done_evt;
  logic [BYTE_W-1:0] hold_data;

  sc_etu_timer #(.ETU_CLKS(ETU_CLKS), .PSEL_W(PSEL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .psel(psel), .half_tick(half_tick)
  );

  sc_tx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .early_end(early_end),
    .par_odd(par_odd), .pending(!flag_empty), .hold_data(hold_data),
    .half_tick(half_tick), .line_i(line_i), .run(run), .restart(restart),
    .line_o(line_o), .line_oe(line_oe), .load_evt(load_evt),
    .err_evt(err_evt), .done_evt(done_evt)
  );

  sc_tx_status u_status (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cpu_wr(cpu_wr),
    .cpu_data(cpu_data), .dma_wr(dma_wr), .dma_data(dma_data),
    .st_rd(st_rd), .st_wr(st_wr), .st_wdata(st_wdata),
    .load_evt(load_evt), .err_evt(err_evt), .done_evt(done_evt),
    .hold_data(hold_data), .empty(flag_empty), .err(flag_err),
    .tend(flag_tend)
  );

  assign txe_req = tx_en && flag_empty;

endmodule

// File: rtl/sc_tx_checker.sv
module sc_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic dma_wr,
  input logic st_wr,
  input logic st_err_bit,
  input logic line_o,
  input logic line_oe,
  input logic flag_err,
  input logic flag_tend
);

  // R3: a released line reads high
  p_release_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> line_o);

  // R4 / R5: no transmit end while a character is on the line
  p_no_tend_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> !flag_tend);

  // R9: a DMA write clears transmit end
  p_dma_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr && tx_en) |=> !flag_tend);

  // R10: disabled with no error forces transmit end
  p_force_tend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !flag_err) |=> flag_tend);

  // R11: error flag sticky until cleared by a status write
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_err && !(st_wr && !st_err_bit)) |=> flag_err);

  // R11: transmit end never rises while the error flag is set
  p_tend_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_tend) |-> $past(!flag_err));

endmodule

bind sc_tx_top sc_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .dma_wr(dma_wr),
  .st_wr(st_wr), .st_err_bit(st_wdata[1]), .line_o(line_o),
  .line_oe(line_oe), .flag_err(flag_err), .flag_tend(flag_tend)
);

// File: tb/tb_sc_tx_top.sv
module tb_sc_tx_top;

  localparam int unsigned ETU = 8;
  localparam int unsigned NV  = 6;
  // {psel[1:0], early, odd, data[7:0]}
  localparam logic [11:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 8'hA5},
    {2'd0, 1'b1, 1'b1, 8'h00},
    {2'd1, 1'b1, 1'b0, 8'hFF},
    {2'd1, 1'b0, 1'b1, 8'h3C},
    {2'd0, 1'b0, 1'b0, 8'h01},
    {2'd0, 1'b1, 1'b1, 8'h80}
  };

  logic clk, rst_n, tx_en, early_end, par_odd;
  logic [1:0] psel, st_wdata;
  logic cpu_wr, dma_wr, st_rd, st_wr, card_low;
  logic [7:0] cpu_data, dma_data;
  logic line_i, line_o, line_oe, txe_req, flag_empty, flag_err, flag_tend;
  int checks, errors;

  assign line_i = card_low ? 1'b0 : (line_oe ? line_o : 1'b1);

  sc_tx_top #(.ETU_CLKS(ETU), .PSEL_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .early_end(early_end),
    .par_odd(par_odd), .psel(psel), .cpu_wr(cpu_wr), .cpu_data(cpu_data),
    .dma_wr(dma_wr), .dma_data(dma_data), .st_rd(st_rd), .st_wr(st_wr),
    .st_wdata(st_wdata), .line_i(line_i), .line_o(line_o),
    .line_oe(line_oe), .txe_req(txe_req), .flag_empty(flag_empty),
    .flag_err(flag_err), .flag_tend(flag_tend)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] d);
    cpu_data = d; cpu_wr = 1'b1; cyc(1); cpu_wr = 1'b0;
  endtask

  task automatic stat_read();
    st_rd = 1'b1; cyc(1); st_rd = 1'b0;
  endtask

  task automatic stat_write(input logic [1:0] w);
    st_wdata = w; st_wr = 1'b1; cyc(1); st_wr = 1'b0; st_wdata = 2'b11;
  endtask

  task automatic wait_oe();
    int n = 0;
    while (!line_oe && n < 2000) begin cyc(1); n++; end
  endtask

  // samples the ten bit centres; returns at offset 19*half
  task automatic capture(input int half, output logic [9:0] got);
    int pos = 0;
    for (int k = 0; k < 10; k++) begin
      cyc((2*k+1)*half - pos);
      pos = (2*k+1)*half;
      got[k] = line_o;
    end
  endtask

  function automatic logic [9:0] frame_of(input logic [7:0] d, input logic odd);
    return {(^d) ^ odd, d, 1'b0};
  endfunction

  logic [9:0] got;
  int half, endh;

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; tx_en = 1'b0; early_end = 1'b0; par_odd = 1'b0; psel = 2'd0;
    cpu_wr = 1'b0; dma_wr = 1'b0; st_rd = 1'b0; st_wr = 1'b0;
    st_wdata = 2'b11; cpu_data = '0; dma_data = '0; card_low = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1 tend", flag_tend, 1);
    check("R1 empty", flag_empty, 1);
    check("R1 err", flag_err, 0);
    check("R1 oe", line_oe, 0);
    check("R1 line", line_o, 1);
    check("R4 req off", txe_req, 0);
    tx_en = 1'b1;
    cyc(1);
    check("R4 req on", txe_req, 1);
    // R8 clear without a prior read has no effect
    stat_write(2'b10);
    check("R8 no-read empty", flag_empty, 1);
    check("R8 no-read tend", flag_tend, 1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      par_odd = VEC[v][8]; early_end = VEC[v][9]; psel = VEC[v][11:10];
      half = (ETU / 2) << psel;
      endh = early_end ? 22 : 25;
      cpu_write(VEC[v][7:0]);
      stat_read();
      stat_write(2'b10);
      check("R8 tend cleared", flag_tend, 0);
      check("R8 empty cleared", flag_empty, 0);
      wait_oe();
      check("R4 empty after load", flag_empty, 1);
      capture(half, got);
      check("R2 frame", got, frame_of(VEC[v][7:0], VEC[v][8]));
      cyc(endh*half - 1 - 19*half);
      check(early_end ? "R6 tend early" : "R5 tend early", flag_tend, 0);
      check("R3 released in guard", line_oe, 0);
      cyc(1);
      check(early_end ? "R6 tend set" : "R5 tend set", flag_tend, 1);
      cyc(3);
    end

    // card error and resend
    par_odd = 1'b0; early_end = 1'b0; psel = 2'd0; half = ETU / 2;
    cpu_write(8'h5A); stat_read(); stat_write(2'b10);
    wait_oe();
    capture(half, got);
    cyc(half + 1); card_low = 1'b1;
    cyc(half);     card_low = 1'b0;
    check("R7 err set", flag_err, 1);
    cyc(25*half - 1 - (21*half + 1));
    check("R7 tend held", flag_tend, 0);
    cyc(1);
    check("R7 resend starts", line_oe, 1);
    check("R7 tend still 0", flag_tend, 0);
    capture(half, got);
    check("R7 same byte", got, frame_of(8'h5A, 1'b0));
    stat_write(2'b11);
    check("R11 err kept", flag_err, 1);
    stat_write(2'b01);
    check("R11 err cleared", flag_err, 0);
    cyc(25*half - 1 - (19*half + 2));
    check("R5 tend before", flag_tend, 0);
    cyc(1);
    check("R5 tend after resend", flag_tend, 1);
    cyc(3);

    // back-to-back characters
    cpu_write(8'hC3); stat_read(); stat_write(2'b10);
    wait_oe();
    capture(half, got);
    cpu_write(8'h96); stat_read(); stat_write(2'b10);
    check("R12 next pending", flag_empty, 0);
    cyc(25*half - 1 - (19*half + 3));
    check("R12 tend low", flag_tend, 0);
    cyc(1);
    check("R12 next starts", line_oe, 1);
    check("R12 tend stays 0", flag_tend, 0);
    capture(half, got);
    check("R12 second byte", got, frame_of(8'h96, 1'b0));
    cyc(25*half - 1 - 19*half);
    cyc(1);
    check("R12 tend at last", flag_tend, 1);
    cyc(3);

    // DMA-style write
    dma_data = 8'h69; dma_wr = 1'b1; cyc(1); dma_wr = 1'b0;
    check("R9 tend cleared", flag_tend, 0);
    check("R9 empty cleared", flag_empty, 0);
    wait_oe();
    capture(half, got);
    check("R9 dma byte", got, frame_of(8'h69, 1'b0));
    cyc(25*half - 19*half);
    check("R9 tend done", flag_tend, 1);
    cyc(3);

    // disable mid character
    cpu_write(8'h11); stat_read(); stat_write(2'b10);
    wait_oe();
    cyc(5);
    tx_en = 1'b0;
    cyc(1);
    check("R10 line released", line_oe, 0);
    check("R10 tend forced", flag_tend, 1);
    tx_en = 1'b1;
    cyc(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule